// File: doc/BRIEF.md
# Link-Side Bus Request Serializer

This block sits on the link side of the link-to-PHY boundary of a serial bus. Link logic posts request commands into it. It keeps one pending slot per request kind and picks the most urgent kind whose issue window is open. It then shifts that request out to the PHY as a short serial frame on a single request line, one bit per clock. It watches the 2-bit control lines coming back from the PHY to tell idle, status, receive and grant/transmit apart.

Arbitrated requests (priority and fair) need a settled idle interface before they go out. They are dropped as lost whenever the PHY shows the receive state, and the block resends them on its own once the interface is idle again. Acknowledge (immediate) and isochronous requests go out only while a packet is arriving. When an acknowledge grant comes for a packet whose header check failed, the block gives the grant back without using it and raises a separate drop pulse instead of the win pulse. Register read and write requests carry an address, and for writes a data byte. The status transfer that answers a read, and all packet data, are handled elsewhere.

Top module: `lreq_issuer`

## Requirements
- R1: A frame is sent MSB first on `lreq`, one bit per clock. It is a start bit of 1, then the 3-bit kind code, then a stop bit of 0. The kind codes are 000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read and 101 register write. A bus request frame is therefore 5 bits long.
- R2: A register read frame puts the 4-bit address between the code and the stop bit, 9 bits in all. A register write frame puts the 4-bit address and then the 8-bit data there, 17 bits in all. Both fields go MSB first. After the stop bit the block is free again without any grant.
- R3: Priority, fair and register frames start only when `ctl` was 00 (idle) on two consecutive rising edges. The start bit appears in the cycle after the second of those edges.
- R4: A fair request goes out only while `fair_ok` is high. A priority request does not depend on `fair_ok`.
- R5: Immediate and isochronous frames start only while `ctl` is 10 (receive).
- R6: If `ctl` shows 10 during a priority or fair frame, the frame is cut off and `lreq` drops. The same happens while the block waits for the result of such a frame. In both cases `lost` pulses for one cycle, `busy` clears, and the same frame is sent again once the interface is idle again.
- R7: When `ctl` shows 11 (grant) after a bus request frame, `won` pulses for one cycle and `won_kind` holds the code of the request that was granted.
- R8: When `hdr_crc_bad` is high as the grant for an immediate request arrives, `imm_drop` pulses, `won` stays low and nothing is sent.
- R9: After an isochronous frame, the isochronous request is not sent again until `iso_done` pulses or a frame of another kind starts. A new isochronous command posted before then has no effect.
- R10: When several requests are eligible at once, they go out in this order: immediate, isochronous, priority, fair, register read, register write.
- R11: Commands with the reserved codes 110 and 111 are ignored, and no such frame is ever sent.
- R12: While `busy` is high, from the first frame bit until the outcome of the request, commands are ignored.
- R13: After reset `lreq`, `busy`, `won`, `imm_drop` and `lost` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_type | input | 3 | Request kind code |
| cmd_addr | input | 4 | Register address for read/write commands |
| cmd_data | input | 8 | Write data for register write commands |
| fair_ok | input | 1 | The fairness interval allows a fair request |
| hdr_crc_bad | input | 1 | The header of the packet now arriving failed its check |
| iso_done | input | 1 | Pulse: the isochronous transfer has finished |
| ctl | input | 2 | PHY state: 00 idle, 01 status, 10 receive, 11 grant |
| lreq | output | 1 | Serial request line to the PHY |
| busy | output | 1 | A frame is in flight or its outcome is awaited |
| won | output | 1 | Pulse: the bus was granted for a request |
| won_kind | output | 3 | Code of the granted request |
| imm_drop | output | 1 | Pulse: an immediate grant was given back unused |
| lost | output | 1 | Pulse: an arbitrated request was lost |

## Verification
The hardest case is a request lost partway through its own frame: the receive state has to arrive while bits are still leaving the block. The stimulus finds the start bit, counts two more clocks, and only then raises the receive code. It then checks that the line drops at once and that the same frame comes back after idle. The ordering case is also awkward to reach, because a single command port cannot post several requests in one cycle. The bench holds the control lines in the status state, where nothing is eligible, while it posts the commands one by one, and then releases the lines to idle.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

  localparam int NKIND = 6;

  typedef enum logic [2:0] {
    K_IMM  = 3'd0,
    K_ISO  = 3'd1,
    K_PRI  = 3'd2,
    K_FAIR = 3'd3,
    K_RD   = 3'd4,
    K_WR   = 3'd5
  } kind_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_STAT = 2'b01;
  localparam logic [1:0] CTL_RX   = 2'b10;
  localparam logic [1:0] CTL_GNT  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_e;

  function automatic logic arb_kind(input logic [2:0] k);
    return (k == K_PRI) || (k == K_FAIR);
  endfunction

  function automatic logic reg_kind(input logic [2:0] k);
    return (k == K_RD) || (k == K_WR);
  endfunction

  function automatic logic code_ok(input logic [2:0] k);
    return k < 3'd6;
  endfunction

endpackage

// File: rtl/lreq_ctl_watch.sv
module lreq_ctl_watch
  import lreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctl,
  output logic       at_idle,
  output logic       at_rx,
  output logic       at_gnt,
  output logic       idle_settled
);
  logic idle_q;

  assign at_idle = (ctl == CTL_IDLE);
  assign at_rx   = (ctl == CTL_RX);
  assign at_gnt  = (ctl == CTL_GNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= at_idle;
  end

  // idle now and idle on the previous edge
  assign idle_settled = at_idle & idle_q;
endmodule

// File: rtl/lreq_pick.sv
module lreq_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  elig,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] first;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_first
      if (i == 0) begin : g_lo
        assign first[i] = elig[i];
      end else begin : g_hi
        assign first[i] = elig[i] & ~(|elig[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = 0; j < N; j++)
      if (first[j]) idx = IW'(j);
  end

  assign hit = |elig;
endmodule

// File: rtl/lreq_shift.sv
module lreq_shift #(
  parameter int W  = 17,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  vec,
  input  logic [CW-1:0] len,
  input  logic          abort,
  output logic          bit_out,
  output logic          active,
  output logic          last
);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= vec;
      cnt    <= len - CW'(1);
      active <= 1'b1;
    end else if (active) begin
      if (abort || cnt == '0) begin
        active <= 1'b0;
      end else begin
        sh  <= sh << 1;
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign bit_out = active & sh[W-1];
  assign last    = active & (cnt == '0);
endmodule

// File: rtl/lreq_issuer.sv
module lreq_issuer
  import lreq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              fair_ok,
  input  logic              hdr_crc_bad,
  input  logic              iso_done,
  input  logic [1:0]        ctl,
  output logic              lreq,
  output logic              busy,
  output logic              won,
  output logic [2:0]        won_kind,
  output logic              imm_drop,
  output logic              lost
);
  localparam int FW = 5 + ADDR_W + DATA_W;
  localparam int CW = $clog2(FW + 1);

  function automatic logic [FW-1:0] mk_frame(input logic [2:0] k,
                                             input logic [ADDR_W-1:0] a,
                                             input logic [DATA_W-1:0] d);
    logic [FW-1:0] v;
    if (k == K_RD)      v = {1'b1, k, a, 1'b0, {DATA_W{1'b0}}};
    else if (k == K_WR) v = {1'b1, k, a, d, 1'b0};
    else                v = {1'b1, k, 1'b0, {(ADDR_W + DATA_W){1'b0}}};
    return v;
  endfunction

  function automatic logic [CW-1:0] frame_len(input logic [2:0] k);
    if (k == K_RD)      return CW'(5 + ADDR_W);
    else if (k == K_WR) return CW'(FW);
    else                return CW'(5);
  endfunction

  function automatic logic [NKIND-1:0] kmask(input logic [2:0] k);
    return NKIND'(1) << k;
  endfunction

  st_e               st;
  logic [2:0]        cur;
  logic [NKIND-1:0]  pend, pend_nx, elig;
  logic              iso_sent, iso_sent_nx;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] wr_data;

  logic at_idle, at_rx, at_gnt, idle_settled;
  logic hit;
  logic [2:0] pick_idx;
  logic accept, frame_start, frame_last, abort;
  logic wait_gnt, wait_lost, wait_quit;
  logic sh_active;
  logic [FW-1:0] load_vec;

  lreq_ctl_watch u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .at_idle(at_idle), .at_rx(at_rx), .at_gnt(at_gnt),
    .idle_settled(idle_settled)
  );

  assign elig[K_IMM]  = pend[K_IMM] & at_rx;
  assign elig[K_ISO]  = pend[K_ISO] & ~iso_sent & at_rx;
  assign elig[K_PRI]  = pend[K_PRI] & idle_settled;
  assign elig[K_FAIR] = pend[K_FAIR] & idle_settled & fair_ok;
  assign elig[K_RD]   = pend[K_RD] & idle_settled;
  assign elig[K_WR]   = pend[K_WR] & idle_settled;

  lreq_pick #(.N(NKIND), .IW(3)) u_pick (
    .elig(elig), .hit(hit), .idx(pick_idx)
  );

  assign busy        = (st != S_IDLE);
  assign accept      = cmd_valid & ~busy & code_ok(cmd_type);
  assign frame_start = (st == S_IDLE) & hit;
  assign abort       = (st == S_SEND) & arb_kind(cur) & at_rx;
  assign wait_gnt    = (st == S_WAIT) & at_gnt;
  assign wait_lost   = (st == S_WAIT) & arb_kind(cur) & at_rx;
  assign wait_quit   = (st == S_WAIT) &
                       (((cur == K_IMM) & at_idle) | ((cur == K_ISO) & iso_done));
  assign load_vec    = mk_frame(pick_idx, (pick_idx == K_WR) ? wr_addr : rd_addr, wr_data);

  lreq_shift #(.W(FW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(frame_start), .vec(load_vec), .len(frame_len(pick_idx)),
    .abort(abort),
    .bit_out(lreq), .active(sh_active), .last(frame_last)
  );

  // pending slots: clears first, a new command last
  always_comb begin
    pend_nx     = pend;
    iso_sent_nx = iso_sent;
    if (wait_gnt && cur != K_ISO)
      pend_nx = pend_nx & ~kmask(cur);
    if (st == S_SEND && frame_last && reg_kind(cur))
      pend_nx = pend_nx & ~kmask(cur);
    if (iso_done || (frame_start && pick_idx != K_ISO)) begin
      pend_nx[K_ISO] = 1'b0;
      iso_sent_nx    = 1'b0;
    end
    if (frame_start && pick_idx == K_ISO)
      iso_sent_nx = 1'b1;
    if (accept)
      pend_nx = pend_nx | kmask(cmd_type);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      iso_sent <= 1'b0;
      rd_addr  <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      pend     <= pend_nx;
      iso_sent <= iso_sent_nx;
      if (accept && cmd_type == K_RD) rd_addr <= cmd_addr;
      if (accept && cmd_type == K_WR) begin
        wr_addr <= cmd_addr;
        wr_data <= cmd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      won      <= 1'b0;
      won_kind <= '0;
      imm_drop <= 1'b0;
      lost     <= 1'b0;
    end else begin
      won      <= 1'b0;
      imm_drop <= 1'b0;
      lost     <= 1'b0;
      case (st)
        S_IDLE: if (frame_start) begin
          st  <= S_SEND;
          cur <= pick_idx;
        end
        S_SEND: if (abort) begin
          st   <= S_IDLE;
          lost <= 1'b1;
        end else if (frame_last) begin
          st <= reg_kind(cur) ? S_IDLE : S_WAIT;
        end
        S_WAIT: if (wait_gnt) begin
          st <= S_IDLE;
          if (cur == K_IMM && hdr_crc_bad) imm_drop <= 1'b1;
          else begin
            won      <= 1'b1;
            won_kind <= cur;
          end
        end else if (wait_lost) begin
          st   <= S_IDLE;
          lost <= 1'b1;
        end else if (wait_quit) begin
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lreq_issuer_chk.sv
module lreq_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl,
  input logic       lreq,
  input logic       busy,
  input logic       won,
  input logic       imm_drop,
  input logic       lost,
  input logic       frame_start,
  input logic [2:0] start_kind,
  input logic       frame_last
);
  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> lreq);

  // R1
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> !lreq);

  // R11
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (start_kind < 3'd6));

  // R3
  arb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && start_kind >= 3'd2) |-> (ctl == 2'b00 && $past(ctl) == 2'b00));

  // R5
  rx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && start_kind < 3'd2) |-> (ctl == 2'b10));

  // R8
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(won && imm_drop));

  // R6
  lost_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> ($past(ctl) == 2'b10 && !busy));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> busy);
endmodule

bind lreq_issuer lreq_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .lreq(lreq), .busy(busy),
  .won(won), .imm_drop(imm_drop), .lost(lost),
  .frame_start(frame_start), .start_kind(pick_idx), .frame_last(frame_last)
);

// File: tb/tb_lreq_issuer.sv
`timescale 1ns/1ps
module tb_lreq_issuer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_type;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_data;
  logic       fair_ok, hdr_crc_bad, iso_done;
  logic [1:0] ctl;
  logic       lreq, busy, won, imm_drop, lost;
  logic [2:0] won_kind;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  lreq_issuer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fair_ok(fair_ok),
    .hdr_crc_bad(hdr_crc_bad), .iso_done(iso_done), .ctl(ctl),
    .lreq(lreq), .busy(busy), .won(won), .won_kind(won_kind),
    .imm_drop(imm_drop), .lost(lost)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic post(input logic [2:0] k, input logic [3:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_type = k; cmd_addr = a; cmd_data = d;
    tick();
    cmd_valid = 1'b0;
  endtask

  // bus frame as the requirement spells it: 1, code, 0
  function automatic int bus_frame(input logic [2:0] k);
    return int'({1'b1, k, 1'b0});
  endfunction

  task automatic wait_start(output bit found, input int limit);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (lreq) begin found = 1'b1; break; end
      tick();
    end
  endtask

  task automatic grab(input int len, output int v);
    v = int'(lreq);
    for (int i = 1; i < len; i++) begin
      tick();
      v = (v << 1) | int'(lreq);
    end
  endtask

  task automatic send_check(input int exp, input int len, input string req);
    bit f; int v;
    wait_start(f, 20);
    chk(f, {req, " frame start"}, int'(f), 1);
    grab(len, v);
    chk(v == exp, {req, " frame bits"}, v, exp);
  endtask

  task automatic grant(input logic [2:0] k, input string req);
    tick();
    ctl = 2'b11;
    tick();
    chk(won == 1'b1 && won_kind == k, {req, " won/kind"}, {won, won_kind}, {1'b1, k});
    ctl = 2'b00;
    tick();
  endtask

  task automatic quiet(input int n, output bit any);
    any = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (lreq) any = 1'b1;
    end
  endtask

  task automatic t_reset();
    // R13
    chk(!lreq && !busy && !won && !imm_drop && !lost, "R13 reset outputs",
        {lreq, busy, won, imm_drop, lost}, 0);
  endtask

  task automatic t_pri_fair_gate();
    bit any;
    fair_ok = 1'b0; ctl = 2'b00;
    post(3'd3, 4'h0, 8'h00);
    quiet(10, any);
    chk(!any, "R4 fair held without fair_ok", any, 0);
    post(3'd2, 4'h0, 8'h00);
    send_check(bus_frame(3'd2), 5, "R1 R4 priority");
    grant(3'd2, "R7 priority");
    fair_ok = 1'b1;
    send_check(bus_frame(3'd3), 5, "R1 R4 fair");
    grant(3'd3, "R7 fair");
  endtask

  task automatic t_idle_window();
    int v;
    ctl = 2'b10;
    post(3'd2, 4'h0, 8'h00);
    repeat (4) tick();
    chk(!lreq, "R3 no start during receive", lreq, 0);
    ctl = 2'b00;
    tick();
    chk(!lreq, "R3 no start after one idle edge", lreq, 0);
    tick();
    chk(lreq, "R3 start after second idle edge", lreq, 1);
    grab(5, v);
    chk(v == bus_frame(3'd2), "R3 frame bits", v, bus_frame(3'd2));
    grant(3'd2, "R3");
  endtask

  task automatic t_lost_retry();
    int v; bit f;
    ctl = 2'b00;
    post(3'd2, 4'h0, 8'h00);
    send_check(bus_frame(3'd2), 5, "R6 first try");
    tick();
    ctl = 2'b10;
    tick();
    chk(lost && !busy, "R6 lost after frame", {lost, busy}, 2'b10);
    repeat (3) tick();
    chk(!lreq, "R6 no resend during receive", lreq, 0);
    ctl = 2'b00;
    send_check(bus_frame(3'd2), 5, "R6 resend");
    grant(3'd2, "R6");
    // lost in mid-frame
    fair_ok = 1'b1;
    post(3'd3, 4'h0, 8'h00);
    wait_start(f, 20);
    chk(f, "R6 mid-frame start", int'(f), 1);
    tick(); tick();
    ctl = 2'b10;
    tick();
    chk(!lreq && lost, "R6 cut off mid-frame", {lreq, lost}, 2'b01);
    ctl = 2'b00;
    wait_start(f, 20);
    grab(5, v);
    chk(f && v == bus_frame(3'd3), "R6 fair resend", v, bus_frame(3'd3));
    grant(3'd3, "R6 fair");
  endtask

  task automatic t_imm();
    bit any;
    ctl = 2'b00; hdr_crc_bad = 1'b0;
    post(3'd0, 4'h0, 8'h00);
    quiet(8, any);
    chk(!any, "R5 immediate held while idle", any, 0);
    ctl = 2'b10;
    send_check(bus_frame(3'd0), 5, "R5 immediate");
    tick();
    ctl = 2'b11;
    tick();
    chk(won && won_kind == 3'd0 && !imm_drop, "R7 immediate won",
        {won, won_kind, imm_drop}, 4'b1000);
    ctl = 2'b10;
    hdr_crc_bad = 1'b1;
    post(3'd0, 4'h0, 8'h00);
    send_check(bus_frame(3'd0), 5, "R8 immediate");
    tick();
    ctl = 2'b11;
    tick();
    chk(imm_drop && !won && !lreq, "R8 bad header gives grant back",
        {imm_drop, won, lreq}, 3'b100);
    ctl = 2'b00; hdr_crc_bad = 1'b0;
    tick();
    chk(!busy, "R8 free after drop", busy, 0);
  endtask

  task automatic t_iso();
    bit any;
    ctl = 2'b10;
    post(3'd1, 4'h0, 8'h00);
    send_check(bus_frame(3'd1), 5, "R5 isochronous");
    grant(3'd1, "R7 isochronous");
    ctl = 2'b10;
    post(3'd1, 4'h0, 8'h00);
    quiet(10, any);
    chk(!any, "R9 no resend before done", any, 0);
    iso_done = 1'b1; tick(); iso_done = 1'b0;
    post(3'd1, 4'h0, 8'h00);
    send_check(bus_frame(3'd1), 5, "R9 after done");
    grant(3'd1, "R9");
    ctl = 2'b00;
    post(3'd4, 4'h3, 8'h00);
    send_check(int'({1'b1, 3'b100, 4'h3, 1'b0}), 9, "R2 read");
    tick();
    ctl = 2'b10;
    post(3'd1, 4'h0, 8'h00);
    send_check(bus_frame(3'd1), 5, "R9 after other kind");
    grant(3'd1, "R9 other");
  endtask

  task automatic t_order();
    bit any;
    ctl = 2'b01; fair_ok = 1'b1;
    post(3'd3, 4'h0, 8'h00);
    post(3'd4, 4'h5, 8'h00);
    post(3'd2, 4'h0, 8'h00);
    quiet(3, any);
    chk(!any, "R10 nothing during status", any, 0);
    ctl = 2'b00;
    send_check(bus_frame(3'd2), 5, "R10 first priority");
    grant(3'd2, "R10");
    send_check(bus_frame(3'd3), 5, "R10 second fair");
    grant(3'd3, "R10");
    send_check(int'({1'b1, 3'b100, 4'h5, 1'b0}), 9, "R10 third read");
    tick();
  endtask

  task automatic t_write();
    bit f; int v;
    ctl = 2'b00;
    post(3'd5, 4'hA, 8'h5C);
    wait_start(f, 20);
    chk(f && busy, "R2 write starts busy", {f, busy}, 2'b11);
    grab(17, v);
    chk(v == int'({1'b1, 3'b101, 4'hA, 8'h5C, 1'b0}), "R2 write bits", v,
        int'({1'b1, 3'b101, 4'hA, 8'h5C, 1'b0}));
    tick();
    chk(!busy && !won, "R2 free after write", {busy, won}, 0);
  endtask

  task automatic t_reserved();
    bit any;
    ctl = 2'b00;
    post(3'd6, 4'h1, 8'h00);
    quiet(10, any);
    chk(!any && !busy, "R11 code 110 ignored", {any, busy}, 0);
    post(3'd7, 4'h1, 8'h00);
    quiet(10, any);
    chk(!any && !busy, "R11 code 111 ignored", {any, busy}, 0);
  endtask

  task automatic t_busy();
    bit f, any; int v;
    ctl = 2'b00;
    post(3'd2, 4'h0, 8'h00);
    wait_start(f, 20);
    cmd_valid = 1'b1; cmd_type = 3'd5; cmd_addr = 4'h9; cmd_data = 8'h33;
    grab(5, v);
    tick();
    cmd_valid = 1'b0;
    chk(f && v == bus_frame(3'd2), "R12 frame while posting", v, bus_frame(3'd2));
    ctl = 2'b11;
    tick();
    ctl = 2'b00;
    quiet(15, any);
    chk(!any, "R12 command during busy ignored", any, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_type = '0; cmd_addr = '0; cmd_data = '0;
    fair_ok = 1'b0; hdr_crc_bad = 1'b0; iso_done = 1'b0; ctl = 2'b00;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (2) tick();
    t_pri_fair_gate();
    t_idle_window();
    t_lost_retry();
    t_imm();
    t_iso();
    t_order();
    t_write();
    t_reserved();
    t_busy();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule